// File: doc/BRIEF.md
# Vector segment address sequencer

This block walks the address and register-index pattern of a vector segment load or store. Each element of the vector owns a segment of one or more consecutive fields in memory. For every element, in order, and for every field of that element, in order, the block emits one beat. A beat carries the element index, the register index that field maps to in that element's lane, and the byte address of the field. A downstream memory request stage takes each beat with a valid/ready handshake. Loads and stores use the same walk. The beat only carries a flag that tells the consumer which direction the operation moves data.

An operation starts with a one-cycle `start` pulse while the block is idle. On that pulse the block captures:

- the base address;
- the vector length;
- the instruction immediate, whose bits above bit 8 hold the field count minus one;
- an element-size code;
- a stride-select bit and an explicit stride;
- the register base;
- the direction flag.

In unit-stride mode the distance between segments is the field count times the element size. In strided mode it is the supplied stride. The block does not touch memory, registers or data alignment, and it raises no exceptions. When the last beat has been accepted it pulses `done`.

Top module: `seg_addr_seq`

## Requirements
- R1: After synchronous reset, `busy`, `beat_valid` and `done` are all 0.
- R2: The field count per segment is `imm[IMM_W-1:9] + 1`, so a zero field gives one beat per element, and an operation issues exactly `vlen` times that count beats.
- R3: Beats run with the element index as the outer loop (0 to `vlen-1`) and the field index as the inner loop. `beat_elem` gives the element index. The first beat is valid in the cycle after the accepted `start`.
- R4: The address of field j of element i is `base_addr + i*S + j*E`, modulo 2^ADDR_W, where S is the segment stride and E is the element size in bytes.
- R5: When `strided` is 0, S equals the field count times E. When `strided` is 1, S is the `stride` input, which is taken as a two's-complement value modulo 2^ADDR_W.
- R6: `beat_reg` of field j is `reg_base + j`, modulo 2^REG_W.
- R7: The `esize` codes 0, 1, 2 and 3 select E = 1, 2, 4 and 8 bytes.
- R8: The sequence advances only on a cycle with `beat_valid` and `beat_ready` both high. While `beat_valid` is high and `beat_ready` is low, all beat outputs hold their values.
- R9: A `start` with `vlen` equal to 0 issues no beat. `done` is 1 in the following cycle.
- R10: `done` is 1 for exactly one cycle, namely the cycle after the final beat is accepted. In that cycle `beat_valid` and `busy` are 0.
- R11: A `start` pulse while `busy` is 1 has no effect on the running operation's beats.
- R12: `beat_store` equals the `is_store` value captured at the accepted `start`, on every beat of that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| base_addr | input | ADDR_W | Starting segment address |
| vlen | input | VL_W | Number of elements |
| imm | input | IMM_W | Instruction immediate; upper bits hold field count minus one |
| esize | input | 2 | Element size code: 0=1, 1=2, 2=4, 3=8 bytes |
| strided | input | 1 | 1 selects the explicit stride |
| stride | input | ADDR_W | Explicit segment stride |
| reg_base | input | REG_W | Register index of field 0 |
| is_store | input | 1 | Direction flag copied to the beats |
| busy | output | 1 | Operation in progress |
| beat_valid | output | 1 | Beat available |
| beat_ready | input | 1 | Consumer accepts the beat |
| beat_elem | output | VL_W | Element index of the beat |
| beat_reg | output | REG_W | Register index of the beat |
| beat_addr | output | ADDR_W | Byte address of the beat |
| beat_store | output | 1 | Direction of the operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a segment boundary hit while the consumer is stalling, combined with address and register wrap-around. At such a boundary the address has to jump back to the running segment base plus the stride, not continue the field walk. The stimulus table therefore includes several cases:

- a base address just below the top of the address space;
- a register base near the top of the index space;
- a negative explicit stride;
- the maximum field count.

The whole table is then replayed with `beat_ready` dropped on a repeating pattern, so stalls land on every position within a segment. Directed cases hold the consumer off while a second `start` arrives, to show that the running walk is not disturbed.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    // bit position where the field-count value begins in the immediate
    localparam int SEG_SHIFT = 9;

    typedef enum logic [1:0] {
        ES_B1 = 2'd0,
        ES_B2 = 2'd1,
        ES_B4 = 2'd2,
        ES_B8 = 2'd3
    } esize_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // element size in bytes for a size code
    function automatic logic [3:0] esize_bytes(input esize_e code);
        logic [3:0] b;
        case (code)
            ES_B1:   b = 4'd1;
            ES_B2:   b = 4'd2;
            ES_B4:   b = 4'd4;
            default: b = 4'd8;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/seqr_loop_ctrl.sv
module seqr_loop_ctrl
    import seqr_pkg::*;
#(
    parameter int VL_W  = 8,
    parameter int FLD_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VL_W-1:0]  vlen,
    input  logic [FLD_W-1:0] fld_last_in,
    input  logic             ready,
    output logic             busy,
    output logic             valid,
    output logic [VL_W-1:0]  elem,
    output logic [FLD_W-1:0] fld,
    output logic             load,
    output logic             adv_field,
    output logic             adv_elem,
    output logic             done
);

    seq_state_e       state_q;
    logic [VL_W-1:0]  vl_q;
    logic [FLD_W-1:0] fld_last_q;
    logic             fire;
    logic             last_fld;
    logic             last_elem;
    logic             zero_start;

    assign busy       = (state_q == ST_RUN);
    assign valid      = busy;
    assign load       = start && !busy && (vlen != '0);
    assign zero_start = start && !busy && (vlen == '0);
    assign fire       = valid && ready;
    assign last_fld   = (fld == fld_last_q);
    assign last_elem  = (elem == vl_q - 1'b1);
    assign adv_field  = fire && !last_fld;
    assign adv_elem   = fire && last_fld && !last_elem;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            vl_q       <= '0;
            fld_last_q <= '0;
            elem       <= '0;
            fld        <= '0;
            done       <= 1'b0;
        end else begin
            done <= zero_start;
            if (load) begin
                state_q    <= ST_RUN;
                vl_q       <= vlen;
                fld_last_q <= fld_last_in;
                elem       <= '0;
                fld        <= '0;
            end else if (fire) begin
                if (last_fld) begin
                    fld <= '0;
                    if (last_elem) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end else begin
                        elem <= elem + 1'b1;
                    end
                end else begin
                    fld <= fld + 1'b1;
                end
            end
        end
    end

    p_fld_bound_r3: assert property (@(posedge clk) disable iff (rst)
        valid |-> (fld <= fld_last_q));

    p_elem_bound_r3: assert property (@(posedge clk) disable iff (rst)
        valid |-> (elem < vl_q));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_zero_vl_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (vlen == '0)) |=> (done && !valid));

endmodule

// File: rtl/seqr_addr_gen.sv
module seqr_addr_gen
    import seqr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int FLD_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              strided,
    input  logic [ADDR_W-1:0] stride_in,
    input  logic [FLD_W:0]    nseg,
    input  esize_e            esize,
    input  logic              adv_field,
    input  logic              adv_elem,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] seg_q;
    logic [ADDR_W-1:0] stride_q;
    logic [3:0]        esz_q;
    logic [ADDR_W-1:0] unit_stride;
    logic [ADDR_W-1:0] next_seg;

    // unit-stride mode: one segment is the field count times the element size
    assign unit_stride = ADDR_W'(nseg) << esize;
    assign next_seg    = seg_q + stride_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q    <= '0;
            stride_q <= '0;
            esz_q    <= 4'd1;
            addr     <= '0;
        end else if (load) begin
            seg_q    <= base;
            addr     <= base;
            stride_q <= strided ? stride_in : unit_stride;
            esz_q    <= esize_bytes(esize);
        end else if (adv_elem) begin
            seg_q <= next_seg;
            addr  <= next_seg;
        end else if (adv_field) begin
            addr <= addr + ADDR_W'(esz_q);
        end
    end

    p_elem_realign_r4: assert property (@(posedge clk) disable iff (rst)
        adv_elem |=> (addr == seg_q));

    p_load_base_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (addr == seg_q));

endmodule

// File: rtl/seg_addr_seq.sv
module seg_addr_seq
    import seqr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VL_W   = 8,
    parameter int REG_W  = 5,
    parameter int IMM_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [VL_W-1:0]   vlen,
    input  logic [IMM_W-1:0]  imm,
    input  logic [1:0]        esize,
    input  logic              strided,
    input  logic [ADDR_W-1:0] stride,
    input  logic [REG_W-1:0]  reg_base,
    input  logic              is_store,
    output logic              busy,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [VL_W-1:0]   beat_elem,
    output logic [REG_W-1:0]  beat_reg,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_store,
    output logic              done
);

    localparam int FLD_W = IMM_W - SEG_SHIFT;

    typedef struct packed {
        logic [VL_W-1:0]   elem;
        logic [REG_W-1:0]  regi;
        logic [ADDR_W-1:0] addr;
    } beat_t;

    logic [FLD_W-1:0]  fld_last;
    logic [FLD_W:0]    nseg;
    logic [FLD_W-1:0]  fld;
    logic [VL_W-1:0]   elem;
    logic [ADDR_W-1:0] addr;
    logic              load;
    logic              adv_field;
    logic              adv_elem;
    logic [REG_W-1:0]  reg_base_q;
    logic              store_q;
    beat_t             beat;

    assign fld_last = imm[IMM_W-1:SEG_SHIFT];
    assign nseg     = {1'b0, fld_last} + 1'b1;

    seqr_loop_ctrl #(.VL_W(VL_W), .FLD_W(FLD_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .vlen        (vlen),
        .fld_last_in (fld_last),
        .ready       (beat_ready),
        .busy        (busy),
        .valid       (beat_valid),
        .elem        (elem),
        .fld         (fld),
        .load        (load),
        .adv_field   (adv_field),
        .adv_elem    (adv_elem),
        .done        (done)
    );

    seqr_addr_gen #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .base      (base_addr),
        .strided   (strided),
        .stride_in (stride),
        .nseg      (nseg),
        .esize     (esize_e'(esize)),
        .adv_field (adv_field),
        .adv_elem  (adv_elem),
        .addr      (addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_base_q <= '0;
            store_q    <= 1'b0;
        end else if (load) begin
            reg_base_q <= reg_base;
            store_q    <= is_store;
        end
    end

    assign beat.elem  = elem;
    assign beat.regi  = reg_base_q + REG_W'(fld);
    assign beat.addr  = addr;

    assign beat_elem  = beat.elem;
    assign beat_reg   = beat.regi;
    assign beat_addr  = beat.addr;
    assign beat_store = store_q;

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=>
            (beat_valid && $stable(beat_addr) && $stable(beat_elem) && $stable(beat_reg)));

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!beat_valid && !busy));

    p_store_const_r12: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && $past(beat_valid)) |-> $stable(beat_store));

    p_first_beat_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (vlen != '0)) |=> (beat_valid && (beat_elem == '0) && (beat_addr == $past(base_addr))));

endmodule

// File: tb/seg_addr_seq_test.sv
module seg_addr_seq_test;

    localparam int ADDR_W = 32;
    localparam int VL_W   = 8;
    localparam int REG_W  = 5;
    localparam int IMM_W  = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [VL_W-1:0]   vlen = '0;
    logic [IMM_W-1:0]  imm = '0;
    logic [1:0]        esize = '0;
    logic              strided = 1'b0;
    logic [ADDR_W-1:0] stride = '0;
    logic [REG_W-1:0]  reg_base = '0;
    logic              is_store = 1'b0;
    logic              beat_ready = 1'b0;
    logic              busy, beat_valid, beat_store, done;
    logic [VL_W-1:0]   beat_elem;
    logic [REG_W-1:0]  beat_reg;
    logic [ADDR_W-1:0] beat_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    seg_addr_seq #(.ADDR_W(ADDR_W), .VL_W(VL_W), .REG_W(REG_W), .IMM_W(IMM_W)) uut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .vlen(vlen),
        .imm(imm), .esize(esize), .strided(strided), .stride(stride),
        .reg_base(reg_base), .is_store(is_store), .busy(busy),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_elem(beat_elem),
        .beat_reg(beat_reg), .beat_addr(beat_addr), .beat_store(beat_store), .done(done)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct packed {
        logic [31:0] base;
        logic [7:0]  vl;
        logic [2:0]  seg;
        logic [1:0]  code;
        logic        strd;
        logic [31:0] strv;
        logic [4:0]  rd;
        logic        st;
        logic [31:0] last_addr;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 8'd4, 3'd0, 2'd2, 1'b0, 32'h0,         5'd3,  1'b0, 32'h0000_100C},
        '{32'h0000_2000, 8'd3, 3'd2, 2'd1, 1'b0, 32'h0,         5'd7,  1'b0, 32'h0000_2010},
        '{32'h0000_8000, 8'd5, 3'd1, 2'd3, 1'b1, 32'h100,       5'd10, 1'b1, 32'h0000_8408},
        '{32'hFFFF_FFFA, 8'd2, 3'd3, 2'd0, 1'b0, 32'h0,         5'd30, 1'b0, 32'h0000_0001},
        '{32'h0000_0040, 8'd1, 3'd7, 2'd3, 1'b0, 32'h0,         5'd0,  1'b1, 32'h0000_0078},
        '{32'h0000_0500, 8'd3, 3'd0, 2'd0, 1'b1, 32'hFFFF_FFF0, 5'd12, 1'b1, 32'h0000_04E0}
    };

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic issue(input vec_t v, input bit stall);
        @(negedge clk);
        base_addr = v.base; vlen = v.vl; imm = {v.seg, 9'h1A5};
        esize = v.code; strided = v.strd; stride = v.strv;
        reg_base = v.rd; is_store = v.st; start = 1'b1;
        beat_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(beat_valid == 1'b1, "R3 first beat valid", 32'(beat_valid), 32'd1);
    endtask

    // walk one operation, comparing every beat to the model
    task automatic walk(input vec_t v, input bit stall);
        int n;
        int k;
        int beats;
        logic [31:0] esz, sstr, exp_addr, last_seen;
        logic [4:0]  exp_reg;
        n = int'(v.seg) + 1;
        esz = 32'd1 << v.code;
        sstr = v.strd ? v.strv : (32'(n) << v.code);
        beats = 0;
        k = 0;
        last_seen = '0;
        for (int i = 0; i < int'(v.vl); i++) begin
            for (int j = 0; j < n; j++) begin
                exp_addr = v.base + 32'(i) * sstr + 32'(j) * esz;
                exp_reg  = v.rd + 5'(j);
                // stall on a pattern until the beat is accepted
                while (stall && (k % 3 == 1)) begin
                    beat_ready = 1'b0;
                    @(negedge clk);
                    k++;
                end
                chk(beat_valid == 1'b1, "R8 valid held", 32'(beat_valid), 32'd1);
                chk(beat_elem == 8'(i), "R3 elem order", 32'(beat_elem), 32'(i));
                chk(beat_addr == exp_addr, "R4 R5 R7 address", beat_addr, exp_addr);
                chk(beat_reg == exp_reg, "R6 register index", 32'(beat_reg), 32'(exp_reg));
                chk(beat_store == v.st, "R12 direction", 32'(beat_store), 32'(v.st));
                last_seen = beat_addr;
                beat_ready = 1'b1;
                beats++;
                @(negedge clk);
                k++;
            end
        end
        beat_ready = 1'b0;
        chk(beats == int'(v.vl) * n, "R2 beat count", 32'(beats), 32'(int'(v.vl) * n));
        chk(last_seen == v.last_addr, "R4 final address", last_seen, v.last_addr);
        chk(done == 1'b1 && beat_valid == 1'b0 && busy == 1'b0, "R10 done pulse",
            {29'b0, done, beat_valid, busy}, 32'b100);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && beat_valid == 1'b0 && done == 1'b0, "R1 reset state",
            {29'b0, busy, beat_valid, done}, 32'd0);

        // table walk: free-running consumer, then with stalls
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < NV; t++) begin
                issue(VECS[t], p == 1);
                walk(VECS[t], p == 1);
            end
        end

        // R9 zero length
        @(negedge clk);
        base_addr = 32'h1234; vlen = 8'd0; imm = 12'h600; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && beat_valid == 1'b0, "R9 zero length done",
            {30'b0, done, beat_valid}, 32'b10);
        @(negedge clk);
        chk(done == 1'b0 && beat_valid == 1'b0, "R9 no beat after",
            {30'b0, done, beat_valid}, 32'b00);

        // R8 hold under stall, R11 start ignored while busy
        issue(VECS[1], 1'b0);
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            chk(beat_addr == 32'h2000 && beat_elem == 8'd0 && beat_reg == 5'd7,
                "R8 hold while stalled", beat_addr, 32'h2000);
        end
        base_addr = 32'h9000; vlen = 8'd9; is_store = 1'b1; reg_base = 5'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(beat_addr == 32'h2000 && busy == 1'b1, "R11 start ignored addr", beat_addr, 32'h2000);
        chk(beat_store == 1'b0 && beat_reg == 5'd7, "R11 start ignored fields",
            {26'b0, beat_store, beat_reg}, 32'd7);
        walk(VECS[1], 1'b0);

        summary();
        $finish;
    end

endmodule